// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block chooses which of several DMA channels gets the system bus next. Each channel can be requested by a hardware request line or by a software request bit. The request line's active level can be programmed. A per-channel mask and a global enable decide whether a request counts. When at least one request qualifies, the arbiter raises a hold request toward the host. It waits for the host's hold acknowledge. It then latches one winning channel and drives that channel's acknowledge line, whose active level can also be programmed.

The winner is reported to the transfer sequencer as a channel number with a valid flag. The choice stays frozen until the sequencer pulses `svc_done`. At that point the hold request is withdrawn for one cycle and the served channel is recorded. The arbiter then requests the bus again if work is still pending. Priority is either fixed, with the lowest channel number winning, or rotating, where the most recently served channel drops to the bottom. The priority mode can be changed between services.

Top module: `dma_req_arbiter`

## Requirements
- R1: With `cfg_rotate`=0 the qualifying channel with the smallest index wins.
- R2: With `cfg_rotate`=1 the search starts at the channel just above the last one served (wrapping from NCH-1 to 0) and proceeds upward. After reset the search starts at channel 0. The last-served channel is recorded on every `svc_done`, whichever mode is selected.
- R3: A hardware request is active when `dreq[i]` equals 1 with `cfg_req_low`=0, and when `dreq[i]` equals 0 with `cfg_req_low`=1.
- R4: `dack` bits are all 0 when idle with `cfg_ack_low`=0 and all 1 with `cfg_ack_low`=1. During a grant exactly the winner's bit takes the opposite, active level.
- R5: A channel whose `ch_mask` bit is 1 is never granted and does not by itself raise `hold_req`.
- R6: `sw_req[i]`=1 acts as an active hardware request on channel i.
- R7: With `cfg_enable`=0 no request qualifies: `hold_req` stays low and no grant is made.
- R8: `hold_req` rises on the clock edge after a qualifying request is seen in idle. The grant (`grant_valid`, `grant_chan`, `dack`) appears on the edge after `hold_ack` is sampled high while a request still qualifies.
- R9: Once granted, `grant_chan` and `dack` stay unchanged whatever the request, mask or acknowledge inputs do, until `svc_done`.
- R10: On the edge that samples `svc_done` during a grant, `hold_req`, `grant_valid` and the active `dack` fall. `hold_req` rises again on the following edge if a request still qualifies.
- R11: After reset `hold_req`=0, `grant_valid`=0, and `dack` is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Global controller enable |
| cfg_rotate | input | 1 | 0 fixed priority, 1 rotating priority |
| cfg_req_low | input | 1 | Hardware request lines are active low |
| cfg_ack_low | input | 1 | Acknowledge lines are active low |
| ch_mask | input | NCH | Per-channel mask, 1 blocks the channel |
| sw_req | input | NCH | Software request bits |
| dreq | input | NCH | Hardware request lines |
| hold_ack | input | 1 | Host has released the bus |
| svc_done | input | 1 | Sequencer has finished the current service |
| hold_req | output | 1 | Bus hold request to the host |
| dack | output | NCH | Channel acknowledge lines |
| grant_valid | output | 1 | A channel currently owns the bus |
| grant_chan | output | $clog2(NCH) | Index of the owning channel |

## Verification
The bench builds the arbiter with its default of four channels. This keeps every request pattern and every mask pattern small enough to sweep in full. The sweep covers all sixteen combinations of enable, priority mode and the two polarities. A bench model of the rotation pointer, carried from one service to the next, therefore meets every wrap-around case of the rotating search. Within each service the bench also checks the hold/acknowledge handshake cycle by cycle. It disturbs the inputs while a grant is held and checks that the released hold request comes back.

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NCH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_enable,
  input  logic                         cfg_rotate,
  input  logic                         cfg_req_low,
  input  logic                         cfg_ack_low,
  input  logic [NCH-1:0]               ch_mask,
  input  logic [NCH-1:0]               sw_req,
  input  logic [NCH-1:0]               dreq,
  input  logic                         hold_ack,
  input  logic                         svc_done,
  output logic                         hold_req,
  output logic [NCH-1:0]               dack,
  output logic                         grant_valid,
  output logic [$clog2(NCH)-1:0]       grant_chan
);
  localparam int CW = $clog2(NCH);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_OWN} state_t;
  state_t state;

  logic [NCH-1:0] hw_act, pend;
  logic [CW-1:0]  top, pick;
  logic           any;

  assign hw_act = dreq ^ {NCH{cfg_req_low}};
  assign pend   = cfg_enable ? ((hw_act | sw_req) & ~ch_mask) : '0;
  assign any    = |pend;

  always_comb begin
    logic found;
    int   j;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NCH; k++) begin
      j = (cfg_rotate ? int'(top) : 0) + k;
      if (j >= NCH) j = j - NCH;
      if (!found && pend[j]) begin
        found = 1'b1;
        pick  = CW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      grant_chan <= '0;
      top        <= '0;
    end else begin
      case (state)
        S_IDLE: if (any) state <= S_WAIT;
        S_WAIT: begin
          if (!any) state <= S_IDLE;
          else if (hold_ack) begin
            state      <= S_OWN;
            grant_chan <= pick;
          end
        end
        S_OWN: if (svc_done) begin
          state <= S_IDLE;
          top   <= (int'(grant_chan) == NCH-1) ? '0 : grant_chan + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign hold_req    = (state != S_IDLE);
  assign grant_valid = (state == S_OWN);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ack
      assign dack[i] = cfg_ack_low ^ (grant_valid && int'(grant_chan) == i);
    end
  endgenerate
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_enable,
  input logic                   cfg_ack_low,
  input logic [NCH-1:0]         ch_mask,
  input logic                   hold_ack,
  input logic                   svc_done,
  input logic                   hold_req,
  input logic [NCH-1:0]         dack,
  input logic                   grant_valid,
  input logic [$clog2(NCH)-1:0] grant_chan
);
  logic [NCH-1:0] ack_act;
  assign ack_act = dack ^ {NCH{cfg_ack_low}};

  a_r4_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_act));

  a_r5_masked_not_won: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> ((($past(ch_mask) >> grant_chan) & 1) == 0));

  a_r7_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> $past(cfg_enable));

  a_r8_grant_after_hlda: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> $past(hold_ack) && $past(hold_req));

  a_r9_winner_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !svc_done |=> grant_valid && $stable(grant_chan));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && svc_done |=> !hold_req && !grant_valid);
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ack_low(cfg_ack_low),
  .ch_mask(ch_mask), .hold_ack(hold_ack), .svc_done(svc_done),
  .hold_req(hold_req), .dack(dack), .grant_valid(grant_valid),
  .grant_chan(grant_chan)
);

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_rotate = 0, cfg_req_low = 0, cfg_ack_low = 0;
  logic [3:0] ch_mask = 0, sw_req = 0, dreq = 0;
  logic hold_ack = 0, svc_done = 0;
  logic hold_req, grant_valid;
  logic [3:0] dack;
  logic [1:0] grant_chan;
  int n_vec = 0, n_bad = 0;
  int top = 0;

  always #2.5 clk = ~clk;

  dma_req_arbiter #(.NCH(NCH)) i_dma_req_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_rotate(cfg_rotate),
    .cfg_req_low(cfg_req_low), .cfg_ack_low(cfg_ack_low), .ch_mask(ch_mask),
    .sw_req(sw_req), .dreq(dreq), .hold_ack(hold_ack), .svc_done(svc_done),
    .hold_req(hold_req), .dack(dack), .grant_valid(grant_valid),
    .grant_chan(grant_chan)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] idle_ack();
    return cfg_ack_low ? 4'hF : 4'h0;
  endfunction

  task automatic service(input logic [3:0] raw, input logic [3:0] sw, input logic [3:0] m);
    logic [3:0] pend, dsave;
    int win;
    dreq = raw; sw_req = sw; ch_mask = m; hold_ack = 0; svc_done = 0;
    // R3 R6 R5 R7: qualifying requests
    pend = cfg_enable ? (((raw ^ {4{cfg_req_low}}) | sw) & ~m) : 4'h0;
    win = -1;
    for (int k = 0; k < 4; k++) begin
      int c;
      c = ((cfg_rotate ? top : 0) + k) % 4;
      if (win < 0 && pend[c]) win = c;
    end
    @(negedge clk);
    check(hold_req == (pend != 0), "R8/R7 hold_req", hold_req, pend != 0);
    check(!grant_valid && dack == idle_ack(), "R4 idle ack", dack, idle_ack());
    if (win < 0) return;
    hold_ack = 1;
    @(negedge clk);
    check(grant_valid, "R8 grant after hold_ack", grant_valid, 1);
    check(grant_chan == win, cfg_rotate ? "R2 rotating winner" : "R1 fixed winner", grant_chan, win);
    check(dack == (idle_ack() ^ (4'h1 << win)), "R4 dack level", dack, idle_ack() ^ (4'h1 << win));
    dsave = dack;
    dreq = ~raw; sw_req = ~sw; ch_mask = ~m; hold_ack = 0;
    @(negedge clk);
    check(grant_valid && grant_chan == win && dack == dsave, "R9 winner frozen", grant_chan, win);
    dreq = raw; sw_req = sw; ch_mask = m; svc_done = 1;
    @(negedge clk);
    check(!hold_req && !grant_valid && dack == idle_ack(), "R10 release", hold_req, 0);
    svc_done = 0;
    top = (win + 1) % 4;
    @(negedge clk);
    check(hold_req == (pend != 0), "R10 re-raise", hold_req, pend != 0);
  endtask

  initial begin
    #10000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!hold_req && !grant_valid && dack == 4'h0, "R11 reset state", dack, 0);
    rst_n = 1;
    @(negedge clk);
    check(!hold_req && !grant_valid, "R11 after release", hold_req, 0);
    for (int cfg = 0; cfg < 16; cfg++) begin
      cfg_enable  = cfg[3] | (cfg[2:0] == 3'd0) ? 1'b1 : 1'b0;
      if (cfg == 8) cfg_enable = 0;
      cfg_rotate  = cfg[0];
      cfg_req_low = cfg[1];
      cfg_ack_low = cfg[2];
      for (int r = 0; r < 16; r++)
        for (int m = 0; m < 16; m++)
          service(4'(r), 4'((r * 5 + m) >> 3) & ~4'(r), 4'(m));
    end
    // R7: enable off with every channel requesting stays silent
    cfg_enable = 0; cfg_req_low = 0;
    service(4'hF, 4'hF, 4'h0);
    @(negedge clk);
    check(!hold_req && !grant_valid, "R7 disabled", hold_req, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule